// File: doc/BRIEF.md
# Power-Management Command Port Decoder

This block sits behind a byte-wide command port used by firmware and the operating system to switch the platform between legacy power management and ACPI mode. Two reserved command codes turn the SCI-enable bit on or off. Every other code is a request for a system management interrupt, which goes out as a single-clock pulse, but only when a gate bit in a local configuration byte is set.

The configuration byte is written through its own strobe. Its reset value depends on whether the platform supports system management mode: with support it resets to zero (gate closed); without support it resets with the gate bit set. The last command byte written is held and presented on an output for read-back.

Top module: `apm_ctrl_port`

## Requirements
- R1: After reset `sci_en` is 0 (legacy mode), `smi_pulse` is 0 and `cmd_last` is 0x00. `cfg_value` is 0x00 when `SMM_SUPPORTED` is 1, and has only bit `SMI_GATE_BIT` (bit 1 by default, value 0x02) set when it is 0.
- R2: A command write of 0xF1 sets `sci_en` on the clock edge that accepts it, so it is visible in the following cycle.
- R3: A command write of 0xF0 clears `sci_en` on the accepting edge.
- R4: A command write of 0xF1 or 0xF0 never produces a pulse on `smi_pulse`, whatever the configuration byte holds.
- R5: A command write of any other value, while bit 1 of the configuration byte is 1, drives `smi_pulse` high for exactly the one cycle after the accepting edge.
- R6: A command write of any other value, while bit 1 of the configuration byte is 0, leaves `smi_pulse` low and `sci_en` unchanged.
- R7: `cmd_last` shows the byte of the most recent command write, updated on its accepting edge.
- R8: A configuration write replaces `cfg_value` on its edge. When a command write and a configuration write arrive in the same cycle, the SMI gate uses the configuration value held before that edge.
- R9: In a cycle without a command write, `smi_pulse` is low in the next cycle and `sci_en` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_data | input | 8 | New configuration byte |
| sci_en | output | 1 | ACPI mode (SCI-enable) bit |
| smi_pulse | output | 1 | One-cycle system management interrupt request |
| cmd_last | output | 8 | Last command byte written |
| cfg_value | output | 8 | Current configuration byte |

## Verification
The assertions assume the strobes and bytes are stable and defined at each rising edge, and that a write is a single-cycle strobe whose data is valid in that same cycle. The stimulus changes inputs only on the falling edge, keeps every byte defined, and biases the random command bytes toward the two reserved codes so both mode switches and gated requests occur often, including writes to the configuration byte in the same cycle as a command.

// File: rtl/apm_ctrl_pkg.sv
package apm_ctrl_pkg;
   typedef enum logic [1:0] {
      KIND_ACPI_ON  = 2'd0,
      KIND_ACPI_OFF = 2'd1,
      KIND_SMI_REQ  = 2'd2
   } apm_kind_e;
endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
   import apm_ctrl_pkg::*;
#(
   parameter int             CMD_W    = 8,
   parameter logic [CMD_W-1:0] CODE_ON  = 8'hF1,
   parameter logic [CMD_W-1:0] CODE_OFF = 8'hF0
) (
   input  logic [CMD_W-1:0] code,
   output apm_kind_e        kind
);
   always_comb begin
      if (code == CODE_ON)       kind = KIND_ACPI_ON;
      else if (code == CODE_OFF) kind = KIND_ACPI_OFF;
      else                       kind = KIND_SMI_REQ;
   end
endmodule

// File: rtl/apm_cfg_byte.sv
module apm_cfg_byte #(
   parameter int             CFG_W   = 8,
   parameter logic [CFG_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] din,
   output logic [CFG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (wr) q <= din;
   end

   p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> q == $past(din));
   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/apm_mode_state.sv
module apm_mode_state
   import apm_ctrl_pkg::*;
#(
   parameter int CMD_W    = 8,
   parameter int GATE_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CMD_W-1:0] code,
   input  apm_kind_e        kind,
   input  logic [CMD_W-1:0] cfg,
   output logic             sci_en,
   output logic             smi_pulse,
   output logic [CMD_W-1:0] last_code
);
   logic smi_next;
   logic gate_open;

   assign gate_open = cfg[GATE_BIT];
   assign smi_next  = wr && (kind == KIND_SMI_REQ) && gate_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_en    <= 1'b0;
         smi_pulse <= 1'b0;
         last_code <= '0;
      end else begin
         smi_pulse <= smi_next;
         if (wr) begin
            last_code <= code;
            case (kind)
               KIND_ACPI_ON:  sci_en <= 1'b1;
               KIND_ACPI_OFF: sci_en <= 1'b0;
               default:       sci_en <= sci_en;
            endcase
         end
      end
   end

   p_acpi_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind == KIND_ACPI_ON) |=> sci_en);
   p_acpi_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind == KIND_ACPI_OFF) |=> !sci_en);
   p_no_smi_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind != KIND_SMI_REQ) |=> !smi_pulse);
   p_smi_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind == KIND_SMI_REQ && cfg[GATE_BIT]) |=> smi_pulse ##1 (!smi_pulse || $past(wr)));
   p_smi_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind == KIND_SMI_REQ && !cfg[GATE_BIT]) |=> (!smi_pulse && $stable(sci_en)));
   p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> last_code == $past(code));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (!smi_pulse && $stable(sci_en) && $stable(last_code)));
endmodule

// File: rtl/apm_ctrl_port.sv
module apm_ctrl_port
   import apm_ctrl_pkg::*;
#(
   parameter int        CMD_W         = 8,
   parameter logic [7:0] ACPI_ON_CODE  = 8'hF1,
   parameter logic [7:0] ACPI_OFF_CODE = 8'hF0,
   parameter int        SMI_GATE_BIT  = 1,
   parameter bit        SMM_SUPPORTED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_data,
   input  logic             cfg_wr,
   input  logic [CMD_W-1:0] cfg_data,
   output logic             sci_en,
   output logic             smi_pulse,
   output logic [CMD_W-1:0] cmd_last,
   output logic [CMD_W-1:0] cfg_value
);
   localparam logic [CMD_W-1:0] GATE_MASK = CMD_W'(1) << SMI_GATE_BIT;
   localparam logic [CMD_W-1:0] CODE_ON   = CMD_W'(ACPI_ON_CODE);
   localparam logic [CMD_W-1:0] CODE_OFF  = CMD_W'(ACPI_OFF_CODE);

   generate
      if (CMD_W < 8) begin : g_bad_width
         $error("CMD_W must hold a full command byte");
      end
      if (SMI_GATE_BIT >= CMD_W) begin : g_bad_gate
         $error("SMI_GATE_BIT lies outside the configuration byte");
      end
      if (ACPI_ON_CODE == ACPI_OFF_CODE) begin : g_bad_codes
         $error("ACPI on and off codes must differ");
      end
   endgenerate

   logic [CMD_W-1:0] cfg_rst;
   generate
      if (SMM_SUPPORTED) begin : g_smm
         assign cfg_rst = '0;
      end else begin : g_no_smm
         assign cfg_rst = GATE_MASK;
      end
   endgenerate

   apm_kind_e kind;

   apm_cmd_decode #(.CMD_W(CMD_W), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)) u_decode (
      .code (cmd_data),
      .kind (kind)
   );

   apm_cfg_byte #(.CFG_W(CMD_W), .RST_VAL(SMM_SUPPORTED ? '0 : GATE_MASK)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .din   (cfg_data),
      .q     (cfg_value)
   );

   apm_mode_state #(.CMD_W(CMD_W), .GATE_BIT(SMI_GATE_BIT)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cmd_wr),
      .code      (cmd_data),
      .kind      (kind),
      .cfg       (cfg_value),
      .sci_en    (sci_en),
      .smi_pulse (smi_pulse),
      .last_code (cmd_last)
   );

   always_comb begin
      if (!rst_n) begin
         a_reset_r1: assert (cfg_value == cfg_rst && !sci_en && !smi_pulse && cmd_last == '0);
      end
   end
endmodule

// File: tb/apm_ctrl_port_bench.sv
module apm_ctrl_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_data = 8'h00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_data = 8'h00;
   logic       sci_en;
   logic       smi_pulse;
   logic [7:0] cmd_last;
   logic [7:0] cfg_value;

   int total = 0;
   int bad   = 0;

   logic       m_sci;
   logic       m_smi;
   logic [7:0] m_last;
   logic [7:0] m_cfg;

   always #2.5 clk = ~clk;

   apm_ctrl_port u_apm_ctrl_port (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .cfg_wr(cfg_wr), .cfg_data(cfg_data), .sci_en(sci_en),
      .smi_pulse(smi_pulse), .cmd_last(cmd_last), .cfg_value(cfg_value)
   );

   function automatic string req_of(input logic wr, input logic [7:0] d, input logic [7:0] cfg);
      if (!wr) return "R9";
      if (d == 8'hF1) return "R2";
      if (d == 8'hF0) return "R3";
      if (cfg[1]) return "R5";
      return "R6";
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [7:0] d, input logic cw, input logic [7:0] cd);
      string req;
      @(negedge clk);
      cmd_wr = wr; cmd_data = d; cfg_wr = cw; cfg_data = cd;
      req = req_of(wr, d, m_cfg);
      m_smi = 1'b0;
      if (wr) begin
         if (d == 8'hF1) m_sci = 1'b1;
         else if (d == 8'hF0) m_sci = 1'b0;
         else m_smi = m_cfg[1];
         m_last = d;
      end
      if (cw) m_cfg = cd;
      @(posedge clk);
      #1;
      check(req, "sci_en", {7'd0, sci_en}, {7'd0, m_sci});
      check((wr && (d == 8'hF0 || d == 8'hF1)) ? "R4" : req, "smi_pulse", {7'd0, smi_pulse}, {7'd0, m_smi});
      check("R7", "cmd_last", cmd_last, m_last);
      check("R8", "cfg_value", cfg_value, m_cfg);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      m_sci = 0; m_smi = 0; m_last = 0; m_cfg = 8'h00;
      #12;
      // R1 reset state
      check("R1", "sci_en", {7'd0, sci_en}, 8'd0);
      check("R1", "smi_pulse", {7'd0, smi_pulse}, 8'd0);
      check("R1", "cmd_last", cmd_last, 8'h00);
      check("R1", "cfg_value", cfg_value, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      step(1, 8'h42, 0, 0);            // R6 gate closed
      step(0, 0, 1, 8'h02);            // R8 open gate
      step(1, 8'hF1, 0, 0);            // R2, R4
      step(1, 8'h42, 0, 0);            // R5 pulse
      step(0, 0, 0, 0);                // R5 pulse ends, R9
      step(1, 8'hF0, 0, 0);            // R3, R4 with gate open
      step(1, 8'h00, 1, 8'h00);        // R8 old cfg used
      step(1, 8'h33, 0, 0);            // R6 gate now closed
      step(1, 8'hFF, 1, 8'hFD);        // gate bit clear in new value, old closed
      step(0, 0, 1, 8'h02);
      step(1, 8'hEF, 0, 0);            // R5 back-to-back
      step(1, 8'hF2, 0, 0);

      for (int i = 0; i < 600; i++) begin
         logic [7:0] d;
         int sel;
         sel = $urandom_range(0, 9);
         d = (sel < 2) ? 8'hF1 : (sel < 4) ? 8'hF0 : 8'($urandom);
         step(($urandom_range(0, 3) != 0), d, ($urandom_range(0, 4) == 0), 8'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule